// File: doc/BRIEF.md
# Sticky Reset Cause Register

This block keeps a record of every reset source that has fired since the last true power-on reset, so that software can find out after boot why the chip was reset. It sits in an always-on clock domain. Its only reset is the power-on reset `por_i`, which is synchronous and active high. Each reset source delivers a single-cycle pulse aligned to `clk`. A pulse sets the bit for its source, and it also sets the bits of every reset it implies. A watchdog expiry or a serial-link request causes a hard reset, and a hard reset causes a soft reset, so all of those bits are set together.

Software reads the register through a small bus port at one offset. The same register also holds two other fields:
- a 3-bit boot-configuration strap, captured while the hard reset is held;
- a JTAG status code, which each JTAG event overwrites.

A debug-initiated power-on reset is reported on its own input and leaves the register untouched. The boot-failure flag is the only bit software can clear, and it clears by writing one to it.

Top module: `reset_cause_reg`

## Requirements
- R1: A cycle with `por_i` high sets the whole register to 0x0000_0000 at that clock edge, and sets the read data register to zero as well.
- R2: Once set, a cause bit stays set across any later events until the next `por_i`. Bits are only ever ORed in.
- R3: A pulse on watchdog input n sets the bit for that watchdog, and also sets bit 1 (soft) and bit 0 (hard). The watchdog bits are: watchdog 0 at bit 2, 1 at bit 22, 2 at bit 21, 3 at bit 20, and 4 at bit 3.
- R4: `link_hrst_i` sets bit 23 together with bits 1 and 0. `hard_evt_i` sets bits 1 and 0. `soft_evt_i` sets only bit 1.
- R5: A `jtag_evt_i` pulse loads `jtag_code_i` into bits 9:8. The new code replaces the old field and is not ORed into it.
- R6: A pulse on `jtag_por_i` leaves all 32 bits of the register unchanged.
- R7: While `hard_rst_i` is high, bits 31:29 follow `strap_i` one clock later. Once `hard_rst_i` is low, those bits hold their last value.
- R8: A bus write to offset 0x10 with data bit 16 set clears bit 16. Writing 0 to bit 16 has no effect, and written values never change any other bit.
- R9: If a `boot_fail_i` pulse and a clearing write reach bit 16 in the same cycle, bit 16 ends up set.
- R10: A read at offset 0x10 returns the register value on `rdata_o` one cycle later. A read at any other offset returns zero. Unused bits always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_i | input | 1 | True power-on reset, synchronous, active high |
| hard_rst_i | input | 1 | Hard reset level; strap sampling window |
| strap_i | input | 3 | Boot-configuration source strap |
| wdt_evt_i | input | 5 | Watchdog expiry pulses, one per timer |
| link_hrst_i | input | 1 | Serial-link hard reset request pulse |
| hard_evt_i | input | 1 | Hard reset event pulse |
| soft_evt_i | input | 1 | Soft reset event pulse |
| jtag_evt_i | input | 1 | JTAG reset event pulse |
| jtag_code_i | input | 2 | JTAG status code loaded on event |
| jtag_por_i | input | 1 | Debug-initiated power-on reset pulse (no effect) |
| boot_fail_i | input | 1 | Boot sequencer failure pulse |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of access |
| bus_wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| status_o | output | 32 | Live register contents |

## Verification
A cause bit that is lost or wrongly set shows on `status_o` at the clock edge right after the event. It shows on `rdata_o` one cycle after a read. A broken cascade appears as bit 0 or bit 1 missing next to a watchdog or link bit. JTAG state that is accumulated instead of replaced shows as both code bits set after two different codes. A strap that keeps being sampled, or a clearing write that overrides a set, changes bits 31:29 or bit 16 one edge after the stimulus.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned REG_OFFSET = 'h10;
  localparam int unsigned BIT_HARD   = 0;
  localparam int unsigned BIT_SOFT   = 1;
  localparam int unsigned BIT_LINK   = 23;
  localparam int unsigned BIT_BFAIL  = 16;
  localparam int unsigned JTAG_LSB   = 8;
  localparam int unsigned STRAP_LSB  = 29;
  localparam int unsigned MAX_WDT    = 5;
  localparam logic [DATA_W-1:0] USED_MASK = 32'hE0F1_030F;

  // Bit position of each watchdog cause flag
  function automatic int unsigned wdt_bit(input int unsigned idx);
    case (idx)
      0:       return 2;
      1:       return 22;
      2:       return 21;
      3:       return 20;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/rcs_cause_accum.sv
module rcs_cause_accum #(
  parameter int unsigned NUM_WDT = 5,
  parameter int unsigned DW      = 32
) (
  input  logic               clk,
  input  logic               por_i,
  input  logic [NUM_WDT-1:0] wdt_evt_i,
  input  logic               link_hrst_i,
  input  logic               hard_evt_i,
  input  logic               soft_evt_i,
  input  logic               boot_fail_i,
  input  logic [DW-1:0]      clr_mask_i,
  output logic [DW-1:0]      cause_o
);
  import rcs_pkg::*;

  logic [DW-1:0] set_mask;
  logic [DW-1:0] cause_q;
  logic [DW-1:0] sticky_mask;

  always_comb begin
    sticky_mask = '0;
    sticky_mask[BIT_HARD]  = 1'b1;
    sticky_mask[BIT_SOFT]  = 1'b1;
    sticky_mask[BIT_LINK]  = 1'b1;
    sticky_mask[BIT_BFAIL] = 1'b1;
    for (int i = 0; i < NUM_WDT; i++) sticky_mask[wdt_bit(i)] = 1'b1;
  end

  // Cascade: watchdog / link -> hard -> soft
  always_comb begin
    set_mask = '0;
    for (int i = 0; i < NUM_WDT; i++) begin
      if (wdt_evt_i[i]) begin
        set_mask[wdt_bit(i)] = 1'b1;
        set_mask[BIT_HARD]   = 1'b1;
        set_mask[BIT_SOFT]   = 1'b1;
      end
    end
    if (link_hrst_i) begin
      set_mask[BIT_LINK] = 1'b1;
      set_mask[BIT_HARD] = 1'b1;
      set_mask[BIT_SOFT] = 1'b1;
    end
    if (hard_evt_i) begin
      set_mask[BIT_HARD] = 1'b1;
      set_mask[BIT_SOFT] = 1'b1;
    end
    if (soft_evt_i)  set_mask[BIT_SOFT]  = 1'b1;
    if (boot_fail_i) set_mask[BIT_BFAIL] = 1'b1;
  end

  // Set dominates clear; only the boot-failure bit is clearable
  always_ff @(posedge clk) begin
    if (por_i) cause_q <= '0;
    else       cause_q <= ((cause_q & ~(clr_mask_i & (DW'(1) << BIT_BFAIL)))
                          | set_mask) & sticky_mask;
  end

  assign cause_o = cause_q;

  AST_HARD_STICKY: assert property (@(posedge clk) disable iff (por_i)
    cause_q[BIT_HARD] |=> cause_q[BIT_HARD]); // R2
  AST_WDT_CASCADE: assert property (@(posedge clk) disable iff (por_i)
    (|wdt_evt_i) |=> (cause_q[BIT_HARD] && cause_q[BIT_SOFT])); // R3
  AST_LINK_CASCADE: assert property (@(posedge clk) disable iff (por_i)
    link_hrst_i |=> (cause_q[BIT_LINK] && cause_q[BIT_HARD] && cause_q[BIT_SOFT])); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (por_i)
    boot_fail_i |=> cause_q[BIT_BFAIL]); // R9
endmodule

// File: rtl/rcs_jtag_stat.sv
module rcs_jtag_stat #(
  parameter int unsigned JW = 2
) (
  input  logic          clk,
  input  logic          por_i,
  input  logic          jtag_evt_i,
  input  logic [JW-1:0] jtag_code_i,
  output logic [JW-1:0] code_o
);
  logic [JW-1:0] code_q;

  // Replaced on each event, never accumulated
  always_ff @(posedge clk) begin
    if (por_i)           code_q <= '0;
    else if (jtag_evt_i) code_q <= jtag_code_i;
  end

  assign code_o = code_q;

  AST_JTAG_LOAD: assert property (@(posedge clk) disable iff (por_i)
    jtag_evt_i |=> (code_q == $past(jtag_code_i))); // R5
  AST_JTAG_HOLD: assert property (@(posedge clk) disable iff (por_i)
    !jtag_evt_i |=> $stable(code_q)); // R6
endmodule

// File: rtl/rcs_strap_cap.sv
module rcs_strap_cap #(
  parameter int unsigned SW = 3
) (
  input  logic          clk,
  input  logic          por_i,
  input  logic          hard_rst_i,
  input  logic [SW-1:0] strap_i,
  output logic [SW-1:0] strap_o
);
  logic [SW-1:0] strap_q;

  always_ff @(posedge clk) begin
    if (por_i)           strap_q <= '0;
    else if (hard_rst_i) strap_q <= strap_i;
  end

  assign strap_o = strap_q;

  AST_STRAP_TRACK: assert property (@(posedge clk) disable iff (por_i)
    hard_rst_i |=> (strap_q == $past(strap_i))); // R7
  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (por_i)
    !hard_rst_i |=> $stable(strap_q)); // R7
endmodule

// File: rtl/rcs_bus_port.sv
module rcs_bus_port #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          por_i,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] status_i,
  output logic [DW-1:0] clr_mask_o,
  output logic [DW-1:0] rdata_o
);
  import rcs_pkg::*;

  logic          hit;
  logic [DW-1:0] rdata_q;

  assign hit        = sel_i && (addr_i == AW'(REG_OFFSET));
  assign clr_mask_o = (hit && wr_i) ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (por_i)                rdata_q <= '0;
    else if (sel_i && !wr_i)  rdata_q <= hit ? (status_i & USED_MASK) : '0;
  end

  assign rdata_o = rdata_q;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (por_i)
    ((rdata_q & ~USED_MASK) == '0)); // R10
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (por_i)
    (sel_i && !wr_i && !hit) |=> (rdata_q == '0)); // R10
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg #(
  parameter int unsigned NUM_WDT = 5,
  parameter int unsigned AW      = 8,
  parameter int unsigned DW      = 32,
  parameter int unsigned STRAP_W = 3,
  parameter int unsigned JTAG_W  = 2
) (
  input  logic               clk,
  input  logic               por_i,
  input  logic               hard_rst_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [NUM_WDT-1:0] wdt_evt_i,
  input  logic               link_hrst_i,
  input  logic               hard_evt_i,
  input  logic               soft_evt_i,
  input  logic               jtag_evt_i,
  input  logic [JTAG_W-1:0]  jtag_code_i,
  input  logic               jtag_por_i,
  input  logic               boot_fail_i,
  input  logic               bus_sel_i,
  input  logic               bus_wr_i,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic [DW-1:0]      bus_wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic [DW-1:0]      status_o
);
  import rcs_pkg::*;

  logic [DW-1:0]      cause_w;
  logic [DW-1:0]      clr_mask_w;
  logic [JTAG_W-1:0]  jcode_w;
  logic [STRAP_W-1:0] strap_w;
  logic               jtag_por_seen;

  // Debug power-on reset deliberately reaches no storage element
  assign jtag_por_seen = jtag_por_i;

  rcs_cause_accum #(.NUM_WDT(NUM_WDT), .DW(DW)) u_accum (
    .clk(clk), .por_i(por_i), .wdt_evt_i(wdt_evt_i), .link_hrst_i(link_hrst_i),
    .hard_evt_i(hard_evt_i), .soft_evt_i(soft_evt_i), .boot_fail_i(boot_fail_i),
    .clr_mask_i(clr_mask_w), .cause_o(cause_w));

  rcs_jtag_stat #(.JW(JTAG_W)) u_jtag (
    .clk(clk), .por_i(por_i), .jtag_evt_i(jtag_evt_i),
    .jtag_code_i(jtag_code_i), .code_o(jcode_w));

  rcs_strap_cap #(.SW(STRAP_W)) u_strap (
    .clk(clk), .por_i(por_i), .hard_rst_i(hard_rst_i),
    .strap_i(strap_i), .strap_o(strap_w));

  always_comb begin
    status_o = cause_w;
    status_o[JTAG_LSB +: JTAG_W]   = jcode_w;
    status_o[STRAP_LSB +: STRAP_W] = strap_w;
  end

  rcs_bus_port #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .por_i(por_i), .sel_i(bus_sel_i), .wr_i(bus_wr_i),
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .status_i(status_o),
    .clr_mask_o(clr_mask_w), .rdata_o(rdata_o));

  AST_JTAG_POR_NOP: assert property (@(posedge clk) disable iff (por_i)
    (jtag_por_seen && !jtag_evt_i && !hard_rst_i && !(|wdt_evt_i) && !link_hrst_i
     && !hard_evt_i && !soft_evt_i && !boot_fail_i && !(bus_sel_i && bus_wr_i))
    |=> $stable(status_o)); // R6
endmodule

// File: tb/reset_cause_reg_tb_top.sv
module reset_cause_reg_tb_top;
  logic        clk = 1'b0;
  logic        por_i = 1'b1;
  logic        hard_rst_i = 1'b0;
  logic [2:0]  strap_i = '0;
  logic [4:0]  wdt_evt_i = '0;
  logic        link_hrst_i = 1'b0, hard_evt_i = 1'b0, soft_evt_i = 1'b0;
  logic        jtag_evt_i = 1'b0, jtag_por_i = 1'b0, boot_fail_i = 1'b0;
  logic [1:0]  jtag_code_i = '0;
  logic        bus_sel_i = 1'b0, bus_wr_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] rdata_o, status_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q;

  always #5 clk = ~clk;

  reset_cause_reg dut_i (
    .clk(clk), .por_i(por_i), .hard_rst_i(hard_rst_i), .strap_i(strap_i),
    .wdt_evt_i(wdt_evt_i), .link_hrst_i(link_hrst_i), .hard_evt_i(hard_evt_i),
    .soft_evt_i(soft_evt_i), .jtag_evt_i(jtag_evt_i), .jtag_code_i(jtag_code_i),
    .jtag_por_i(jtag_por_i), .boot_fail_i(boot_fail_i), .bus_sel_i(bus_sel_i),
    .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .rdata_o(rdata_o), .status_o(status_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    wdt_evt_i = '0; link_hrst_i = 0; hard_evt_i = 0; soft_evt_i = 0;
    jtag_evt_i = 0; jtag_por_i = 0; boot_fail_i = 0; bus_sel_i = 0; bus_wr_i = 0;
  endtask

  task automatic bus_read(input logic [7:0] a);
    @(negedge clk); bus_sel_i = 1; bus_wr_i = 0; bus_addr_i = a;
    idle();
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel_i = 1; bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d;
    idle();
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    por_i = 0;
    @(negedge clk);
    chk("R1 status after por", status_o, 32'h0);
    chk("R1 rdata after por", rdata_o, 32'h0);
    exp_q = 32'h0;
  endtask

  task automatic t_strap();
    @(negedge clk); hard_rst_i = 1; strap_i = 3'd5;
    @(negedge clk); chk("R7 strap tracks", status_o, 32'hA000_0000);
    strap_i = 3'd3;
    @(negedge clk); chk("R7 strap tracks again", status_o, 32'h6000_0000);
    hard_rst_i = 0; strap_i = 3'd6;
    @(negedge clk); @(negedge clk);
    exp_q = 32'h6000_0000;
    chk("R7 strap frozen", status_o, exp_q);
  endtask

  task automatic t_cascade();
    @(negedge clk); soft_evt_i = 1; idle();
    exp_q |= 32'h2;
    chk("R4 soft sets only bit1", status_o, exp_q);
    @(negedge clk); link_hrst_i = 1; idle();
    exp_q |= 32'h0080_0003;
    chk("R4 link cascade", status_o, exp_q);
    @(negedge clk); wdt_evt_i = 5'b00010; idle();
    exp_q |= 32'h0040_0000;
    chk("R3 wdt1 bit22", status_o, exp_q);
    @(negedge clk); wdt_evt_i = 5'b10000; idle();
    exp_q |= 32'h0000_0008;
    chk("R3 wdt4 bit3", status_o, exp_q);
    @(negedge clk); wdt_evt_i = 5'b01101; idle();
    exp_q |= 32'h0030_0004;
    chk("R2 R3 wdt0/2/3 accumulate", status_o, exp_q);
  endtask

  task automatic t_jtag();
    @(negedge clk); jtag_evt_i = 1; jtag_code_i = 2'd2; idle();
    chk("R5 jtag code 2", status_o, exp_q | 32'h200);
    @(negedge clk); jtag_evt_i = 1; jtag_code_i = 2'd1; idle();
    exp_q |= 32'h100;
    chk("R5 jtag replaced", status_o, exp_q);
    @(negedge clk); jtag_por_i = 1; idle();
    chk("R6 jtag por no effect", status_o, exp_q);
  endtask

  task automatic t_bootfail();
    @(negedge clk); boot_fail_i = 1; idle();
    exp_q |= 32'h0001_0000;
    chk("R4 R8 boot fail set", status_o, exp_q);
    bus_write(8'h10, 32'h0);
    chk("R8 write zero ignored", status_o, exp_q);
    bus_write(8'h14, 32'hFFFF_FFFF);
    chk("R8 other offset ignored", status_o, exp_q);
    bus_write(8'h10, 32'hFFFF_FFFF);
    exp_q &= ~32'h0001_0000;
    chk("R8 w1c only bit16", status_o, exp_q);
    @(negedge clk); boot_fail_i = 1; bus_sel_i = 1; bus_wr_i = 1;
    bus_addr_i = 8'h10; bus_wdata_i = 32'h0001_0000; idle();
    exp_q |= 32'h0001_0000;
    chk("R9 set beats clear", status_o, exp_q);
  endtask

  task automatic t_read();
    bus_read(8'h10);
    chk("R10 read at offset", rdata_o, exp_q);
    bus_read(8'h14);
    chk("R10 read elsewhere zero", rdata_o, 32'h0);
  endtask

  task automatic t_final_por();
    @(negedge clk); por_i = 1;
    @(negedge clk); por_i = 0;
    chk("R1 por clears all", status_o, 32'h0);
    chk("R1 por clears rdata", rdata_o, 32'h0);
  endtask

  initial begin
    t_reset();
    t_strap();
    t_cascade();
    t_jtag();
    t_bootfail();
    t_read();
    t_final_por();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule